// File: doc/BRIEF.md
# Two-Wire Register Slave with Programmable Station Address

The block is a slave on an I2C-compatible two-wire bus. It gives a bus master read and write access to a byte-wide register file that sits outside the block. SCL and SDA are open-drain lines. The block samples both lines with its own system clock, which runs much faster than SCL. It can only pull SDA low. It never pulls SCL low, and it has no clock stretching.

A transfer opens with a start condition and an address byte. The upper seven bits of that byte are compared with the block's station address. The station address is held inside the block, is written through one register index of the file, and resets to zero. After a write-direction address, the next byte is a sub-address that loads the register index. Every byte after that is written to the file at the current index, and the index then steps up by one. To read, the master sends a repeated start and a read-direction address. The block then returns bytes from the current index, MSB first, and steps the index after each byte, until the master declines to acknowledge.

The register-file port is a single address bus shared by reads and writes. It carries a one-cycle write strobe with write data, and a read-data input that the block samples combinationally at the current index.

Top module: `twr_regslave`

## Requirements
- R1: After reset the block pulls neither line, holds the write strobe low, and has station address 0x00.
- R2: The SCL pull-low output is never asserted.
- R3: An address byte whose bits 7:1 differ from the station address gets no acknowledge. No register is written and SDA is not pulled until the next start.
- R4: A write to register index 0x0F loads bits 6:0 of the data as the station address and ignores bit 7. A read of index 0x0F returns the station address with bit 7 read as 0.
- R5: With the reset station address, the address bytes 0x00 (write) and 0x01 (read) are acknowledged.
- R6: In a write transfer (address byte with bit 0 = 0, sub-address, data bytes), every byte is acknowledged by pulling SDA low during the ninth SCL pulse. Each data byte produces exactly one single-cycle write strobe carrying that byte.
- R7: After a repeated start with an address byte whose bit 0 = 1, the block drives register data MSB first, one bit per SCL pulse.
- R8: The register index increases by one after every data byte, for both writes and reads. It carries across index 0x0F and across separate read transfers.
- R9: When the master leaves SDA high in the acknowledge slot after a read byte, the block stops driving SDA until the next start or stop.
- R10: A start or stop inside a byte abandons that byte without any register write and returns the receiver to address matching.
- R11: A new station address takes effect at the next start condition, including a repeated start.
- R12: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_pull_o | output | 1 | Pull-low enable for SCL, always 0 |
| sda_pull_o | output | 1 | Pull-low enable for SDA |
| rf_addr | output | DATA_W | Register index for reads and writes |
| rf_we | output | 1 | Single-cycle register write strobe |
| rf_wdata | output | DATA_W | Register write data |
| rf_rdata | input | DATA_W | Register read data at rf_addr |

## Verification
Both lines pass through a two-stage synchronizer and an edge register, so the block reacts to an SCL falling edge at the third clock edge after it. That is when it changes its SDA drive (acknowledge, next read bit, release), and also when it raises the write strobe. The index steps one cycle after the strobe. The bench holds each SCL half period for 16 clocks. It samples the acknowledge and read bits 8 clocks into SCL high, and it sets and checks register values only after whole bytes, so every result has settled well before it is observed. A monitor samples at the falling clock edge, records each write strobe into the bench's register model, and flags any change of the SDA drive while SCL is high.

// File: rtl/twr_pkg.sv
package twr_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_MACK
  } twr_state_e;

  typedef enum logic [1:0] {
    P_DEV,
    P_SUB,
    P_WR,
    P_RD
  } twr_phase_e;

endpackage

// File: rtl/twr_insync.sv
module twr_insync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev
);

  logic [STAGES:0][WIDTH-1:0] stg_q;
  logic [STAGES:0][WIDTH-1:0] stg_d;

  assign stg_d = {stg_q[STAGES-1:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '1;
    else        stg_q <= stg_d;
  end

  assign cur  = stg_q[STAGES-1];
  assign prev = stg_q[STAGES];

endmodule

// File: rtl/twr_station.sv
module twr_station #(
  parameter int DATA_W  = 8,
  parameter int STN_IDX = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] idx,
  input  logic [DATA_W-2:0] wdata_lo,
  output logic [DATA_W-2:0] station
);

  logic [DATA_W-2:0] stn_q;
  logic [DATA_W-2:0] stn_d;
  logic              stn_en;

  assign stn_en = we && (idx == DATA_W'(STN_IDX));
  assign stn_d  = stn_en ? wdata_lo : stn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stn_q <= '0;
    else        stn_q <= stn_d;
  end

  assign station = stn_q;

endmodule

// File: rtl/twr_engine.sv
module twr_engine
  import twr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_cur,
  input  logic              scl_prev,
  input  logic              sda_cur,
  input  logic              sda_prev,
  input  logic [DATA_W-2:0] station_i,
  input  logic [DATA_W-1:0] rd_byte_i,
  output logic [DATA_W-1:0] idx_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              pull_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              idle_o
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  twr_state_e        state_q, state_d;
  twr_phase_e        phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] idx_q, idx_d;
  logic [DATA_W-2:0] stn_q, stn_d;
  logic              pull_q, pull_d;
  logic              nack_q, nack_d;
  logic              we_q, we_d;

  logic scl_rise, scl_fall, start_det, stop_det;

  assign scl_rise  = scl_cur & ~scl_prev;
  assign scl_fall  = ~scl_cur & scl_prev;
  assign start_det = scl_cur & scl_prev & sda_prev & ~sda_cur;
  assign stop_det  = scl_cur & scl_prev & ~sda_prev & sda_cur;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    idx_d   = idx_q;
    stn_d   = stn_q;
    pull_d  = pull_q;
    nack_d  = nack_q;
    we_d    = 1'b0;
    if (we_q) idx_d = idx_q + 1'b1;
    if (start_det) begin
      state_d = S_RX;
      phase_d = P_DEV;
      cnt_d   = '0;
      pull_d  = 1'b0;
      stn_d   = station_i;
    end else if (stop_det) begin
      state_d = S_IDLE;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else begin
      unique case (state_q)
        S_RX: begin
          if (scl_rise && (cnt_q < CNT_FULL)) begin
            sh_d  = {sh_q[DATA_W-2:0], sda_cur};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && (cnt_q == CNT_FULL)) begin
            cnt_d   = '0;
            pull_d  = 1'b1;
            state_d = S_ACK;
            unique case (phase_q)
              P_DEV: begin
                if (sh_q[DATA_W-1:1] == stn_q) begin
                  phase_d = sh_q[0] ? P_RD : P_SUB;
                end else begin
                  state_d = S_IDLE;
                  pull_d  = 1'b0;
                end
              end
              P_SUB: begin
                idx_d   = sh_q;
                phase_d = P_WR;
              end
              default: we_d = 1'b1;
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (phase_q == P_RD) begin
              sh_d    = rd_byte_i;
              idx_d   = idx_q + 1'b1;
              pull_d  = ~rd_byte_i[DATA_W-1];
              state_d = S_TX;
            end else begin
              pull_d  = 1'b0;
              state_d = S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              cnt_d   = '0;
              pull_d  = 1'b0;
              state_d = S_MACK;
            end else begin
              cnt_d  = cnt_q + 1'b1;
              sh_d   = {sh_q[DATA_W-2:0], 1'b0};
              pull_d = ~sh_q[DATA_W-2];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            nack_d = sda_cur;
          end else if (scl_fall) begin
            if (nack_q) begin
              state_d = S_IDLE;
            end else begin
              sh_d    = rd_byte_i;
              idx_d   = idx_q + 1'b1;
              pull_d  = ~rd_byte_i[DATA_W-1];
              state_d = S_TX;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      phase_q <= P_DEV;
      cnt_q   <= '0;
      sh_q    <= '0;
      idx_q   <= '0;
      stn_q   <= '0;
      pull_q  <= 1'b0;
      nack_q  <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      idx_q   <= idx_d;
      stn_q   <= stn_d;
      pull_q  <= pull_d;
      nack_q  <= nack_d;
      we_q    <= we_d;
    end
  end

  assign idx_o   = idx_q;
  assign we_o    = we_q;
  assign wdata_o = sh_q;
  assign pull_o  = pull_q;
  assign start_o = start_det;
  assign stop_o  = stop_det;
  assign idle_o  = (state_q == S_IDLE);

endmodule

// File: rtl/twr_regslave.sv
module twr_regslave #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int STN_IDX     = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  output logic [DATA_W-1:0] rf_addr,
  output logic              rf_we,
  output logic [DATA_W-1:0] rf_wdata,
  input  logic [DATA_W-1:0] rf_rdata
);

  localparam int STN_W = DATA_W - 1;

  logic [1:0]        rst_pipe_q;
  logic              rst_core_n;
  logic [1:0]        line_cur, line_prev;
  logic [STN_W-1:0]  stn_val;
  logic [DATA_W-1:0] rd_byte;
  logic              eng_start, eng_stop, eng_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  twr_insync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .din   ({scl_i, sda_i}),
    .cur   (line_cur),
    .prev  (line_prev)
  );

  twr_station #(.DATA_W(DATA_W), .STN_IDX(STN_IDX)) u_stn (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .we       (rf_we),
    .idx      (rf_addr),
    .wdata_lo (rf_wdata[STN_W-1:0]),
    .station  (stn_val)
  );

  assign rd_byte = (rf_addr == DATA_W'(STN_IDX)) ? {1'b0, stn_val} : rf_rdata;

  twr_engine #(.DATA_W(DATA_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .scl_cur   (line_cur[1]),
    .scl_prev  (line_prev[1]),
    .sda_cur   (line_cur[0]),
    .sda_prev  (line_prev[0]),
    .station_i (stn_val),
    .rd_byte_i (rd_byte),
    .idx_o     (rf_addr),
    .we_o      (rf_we),
    .wdata_o   (rf_wdata),
    .pull_o    (sda_pull_o),
    .start_o   (eng_start),
    .stop_o    (eng_stop),
    .idle_o    (eng_idle)
  );

  assign scl_pull_o = 1'b0;

endmodule

// File: rtl/twr_checker.sv
module twr_checker #(
  parameter int DATA_W  = 8,
  parameter int STN_IDX = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_pull_o,
  input logic              rf_we,
  input logic [DATA_W-1:0] rf_addr,
  input logic [DATA_W-2:0] rf_wdata_lo,
  input logic [DATA_W-2:0] station,
  input logic              start_det,
  input logic              stop_det,
  input logic              idle
);

  p_drive_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !scl_i);

  p_we_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  p_index_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> (rf_addr == DATA_W'($past(rf_addr) + 1'b1)));

  p_station_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && (rf_addr == DATA_W'(STN_IDX))) |=> (station == $past(rf_wdata_lo)));

  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_o);

  p_start_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull_o);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_pull_o);

endmodule

bind twr_regslave twr_checker #(.DATA_W(DATA_W), .STN_IDX(STN_IDX)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .scl_i       (scl_i),
  .sda_pull_o  (sda_pull_o),
  .rf_we       (rf_we),
  .rf_addr     (rf_addr),
  .rf_wdata_lo (rf_wdata[DATA_W-2:0]),
  .station     (stn_val),
  .start_det   (eng_start),
  .stop_det    (eng_stop),
  .idle        (eng_idle)
);

// File: tb/sim_twr_regslave.sv
module sim_twr_regslave;

  localparam int Q  = 8;
  localparam int HP = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       m_scl, m_sda;
  logic       scl_pull_o, sda_pull_o;
  logic [7:0] rf_addr, rf_wdata, rf_rdata;
  logic       rf_we;
  wire        scl_line = m_scl & ~scl_pull_o;
  wire        sda_line = m_sda & ~sda_pull_o;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  int checks = 0, failures = 0, we_cnt = 0, scl_hits = 0, r12_bad = 0;
  bit done = 0;
  logic prev_pull = 1'b0, prev_scl = 1'b1;

  always #2 clk = ~clk;

  assign rf_rdata = mem[rf_addr];

  twr_regslave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o),
    .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 7) + 3);
  endfunction

  // Register-file model and line monitors
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    end else begin
      if (rf_we) begin
        mem[rf_addr] = rf_wdata;
        we_cnt++;
      end
      if (scl_pull_o) scl_hits++;
      if (scl_line && prev_scl && (sda_pull_o != prev_pull)) r12_bad++;
    end
    prev_pull = sda_pull_o;
    prev_scl  = scl_line;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(HP);
    m_sda = 1'b0; tick(HP);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(HP);
    m_sda = 1'b1; tick(HP);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      m_sda = b[7-i]; tick(Q);
      m_scl = 1'b1; tick(HP);
      m_scl = 1'b0; tick(Q);
    end
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked);
    put_bits(b, 8);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    acked = !sda_line; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic get_byte(input bit mack, output logic [7:0] b);
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      m_scl = 1'b1; tick(Q);
      b = {b[6:0], sda_line}; tick(Q);
      m_scl = 1'b0; tick(Q);
    end
    m_sda = mack ? 1'b0 : 1'b1; tick(Q);
    m_scl = 1'b1; tick(HP);
    m_scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  task automatic wr_xfer(input logic [6:0] dev, input logic [7:0] sub, input int n, output int nacks);
    bit a;
    nacks = 0;
    bus_start();
    put_byte({dev, 1'b0}, a); if (!a) nacks++;
    put_byte(sub, a);         if (!a) nacks++;
    for (int k = 0; k < n; k++) begin
      put_byte(wbuf[k], a); if (!a) nacks++;
      exp_mem[8'(sub + k)] = wbuf[k];
    end
    bus_stop();
  endtask

  task automatic rd_xfer(input logic [6:0] dev, input logic [7:0] sub, input int n, output int nacks);
    bit a;
    nacks = 0;
    bus_start();
    put_byte({dev, 1'b0}, a); if (!a) nacks++;
    put_byte(sub, a);         if (!a) nacks++;
    bus_start();
    put_byte({dev, 1'b1}, a); if (!a) nacks++;
    for (int k = 0; k < n; k++) get_byte(k != n - 1, rbuf[k]);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("TIMEOUT: watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int nk, base_we, lows, len;
    bit a;
    logic [7:0] sub, b;
    logic [6:0] cur_dev;
    void'($urandom(32'd7031));
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    m_scl = 1'b1; m_sda = 1'b1; rst_n = 1'b0;
    tick(6);
    rst_n = 1'b1;
    tick(10);

    // R1: reset state
    chk(sda_pull_o == 1'b0, "R1 sda pull", sda_pull_o, 0);
    chk(rf_we == 1'b0, "R1 write strobe", rf_we, 0);
    chk(scl_pull_o == 1'b0, "R1 scl pull", scl_pull_o, 0);

    // R5 + R6: reset address 0x00, three-byte write
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    base_we = we_cnt;
    wr_xfer(7'h00, 8'h10, 3, nk);
    chk(nk == 0, "R5/R6 acks", nk, 0);
    chk(we_cnt - base_we == 3, "R6 strobe count", we_cnt - base_we, 3);
    for (int k = 0; k < 3; k++)
      chk(mem[16 + k] == exp_mem[16 + k], "R8 write increment", mem[16 + k], exp_mem[16 + k]);

    // R7: read back
    rd_xfer(7'h00, 8'h10, 3, nk);
    chk(nk == 0, "R7 acks", nk, 0);
    for (int k = 0; k < 3; k++)
      chk(rbuf[k] == exp_mem[16 + k], "R7/R8 read data", rbuf[k], exp_mem[16 + k]);

    // R3: foreign address ignored
    base_we = we_cnt;
    bus_start();
    put_byte(8'h66, a); chk(!a, "R3 no ack on address", a, 0);
    put_byte(8'h11, a); chk(!a, "R3 no ack after mismatch", a, 0);
    put_byte(8'h99, a);
    bus_stop();
    chk(we_cnt == base_we, "R3 no write", we_cnt - base_we, 0);
    chk(mem[8'h11] == exp_mem[8'h11], "R3 register unchanged", mem[8'h11], exp_mem[8'h11]);

    // R4 + R8 + R11: station write, index carries across 0x0F
    wbuf[0] = 8'hEA; wbuf[1] = 8'h5C;
    wr_xfer(7'h00, 8'h0F, 2, nk);
    chk(nk == 0, "R4 acks", nk, 0);
    chk(mem[8'h10] == 8'h5C, "R8 across 0x0F", mem[8'h10], 8'h5C);
    bus_start();
    put_byte(8'h00, a); chk(!a, "R11 old address dropped", a, 0);
    bus_stop();
    bus_start();
    put_byte(8'hD4, a); chk(a, "R11/R4 new address", a, 1);
    bus_stop();
    rd_xfer(7'h6A, 8'h0F, 1, nk);
    chk(nk == 0, "R4 read acks", nk, 0);
    chk(rbuf[0] == 8'h6A, "R4 bit7 reads 0", rbuf[0], 8'h6A);

    // R11: repeated start uses the just-written station
    bus_start();
    put_byte(8'hD4, a);
    put_byte(8'h0F, a);
    put_byte(8'h21, a);
    bus_start();
    put_byte(8'h43, a); chk(a, "R11 repeated start", a, 1);
    get_byte(1'b0, b);
    bus_stop();
    chk(b == 8'h5C, "R11/R8 data after 0x0F", b, 8'h5C);
    cur_dev = 7'h21;

    // R9: master NACK silences the slave
    wbuf[0] = 8'h01; wbuf[1] = 8'h82; wbuf[2] = 8'h03; wbuf[3] = 8'hF4;
    wr_xfer(cur_dev, 8'h20, 4, nk);
    bus_start();
    put_byte({cur_dev, 1'b0}, a);
    put_byte(8'h20, a);
    bus_start();
    put_byte({cur_dev, 1'b1}, a);
    get_byte(1'b1, b); chk(b == 8'h01, "R7 first byte", b, 8'h01);
    get_byte(1'b0, b); chk(b == 8'h82, "R8 read increment", b, 8'h82);
    lows = 0;
    m_sda = 1'b1;
    for (int i = 0; i < 9; i++) begin
      tick(Q); m_scl = 1'b1; tick(Q);
      if (!sda_line) lows++;
      tick(Q); m_scl = 1'b0; tick(Q);
    end
    bus_stop();
    chk(lows == 0, "R9 released after nack", lows, 0);
    bus_start();
    put_byte({cur_dev, 1'b1}, a);
    get_byte(1'b0, b);
    bus_stop();
    chk(b == 8'h03, "R8 index kept between reads", b, 8'h03);

    // R10: start inside the address byte
    bus_start();
    put_bits(8'h5A, 4);
    wbuf[0] = 8'h77;
    wr_xfer(cur_dev, 8'h30, 1, nk);
    chk(nk == 0 && mem[8'h30] == 8'h77, "R10 start abort", mem[8'h30], 8'h77);
    // R10: stop inside a data byte
    base_we = we_cnt;
    bus_start();
    put_byte({cur_dev, 1'b0}, a);
    put_byte(8'h31, a);
    put_bits(8'hAB, 3);
    bus_stop();
    chk(we_cnt == base_we, "R10 no write on stop abort", we_cnt - base_we, 0);
    chk(sda_pull_o == 1'b0, "R10 line released", sda_pull_o, 0);
    rd_xfer(cur_dev, 8'h31, 1, nk);
    chk(nk == 0 && rbuf[0] == exp_mem[8'h31], "R10 back to matching", rbuf[0], exp_mem[8'h31]);

    // Random write/read-back (R6, R7, R8)
    for (int it = 0; it < 16; it++) begin
      sub = 8'h40 + 8'($urandom % 176);
      len = 1 + int'($urandom % 4);
      for (int k = 0; k < len; k++) wbuf[k] = 8'($urandom);
      wr_xfer(cur_dev, sub, len, nk);
      chk(nk == 0, "R6 random acks", nk, 0);
      rd_xfer(cur_dev, sub, len, nk);
      for (int k = 0; k < len; k++)
        chk(rbuf[k] == exp_mem[8'(sub + k)], "R8 random read back", rbuf[k], exp_mem[8'(sub + k)]);
    end

    chk(scl_hits == 0, "R2 scl never pulled", scl_hits, 0);
    chk(r12_bad == 0, "R12 drive changes with scl low", r12_bad, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule